// File: doc/BRIEF.md
# DS3 Frame-Master Serial Transmit Payload Stage

This block is the transmit-side payload entry point of a DS3 framer that runs in serial, locally timed, frame-master mode. One transmit clock (nominally 44.736 MHz, shared with the terminal equipment that shifts the payload out) times everything. The block takes one serial payload bit per rising edge. A free-running slot counter sets the outbound M-frame boundaries on its own, with no external sync input.

Each M-frame holds `SUBFRAMES` x `BLOCKS_PER_SUB` blocks of `BLOCK_BITS` slots each. The default is 7 x 8 x 85 = 4760 slots. The first slot of every block is an overhead slot. In an overhead slot the block raises an overhead flag toward the terminal equipment, ignores the payload bit and puts the register-supplied overhead bit on the serial output instead. A one-slot pulse marks the last slot of every frame. The serial output and both strobes come out of one register stage, so they always describe the same slot, one clock after that slot was sampled.

Top module: `ds3_frame_master_tx`

## Requirements
- R1: In a payload slot, `ser_out` equals the `ser_in` value sampled at the rising edge one clock earlier.
- R2: In an overhead slot, `oh_flag` is 1 and `ser_out` equals the `oh_bit` value sampled at the same edge.
- R3: `frame_end` is 1 for exactly one clock per frame, and that clock describes slot `FRAME_BITS-1`, the last slot of the frame.
- R4: Frames follow one another without a gap. `frame_end` pulses are exactly `FRAME_BITS` clocks apart, and the slot right after a pulse is slot 0, an overhead slot.
- R5: While the synchronous active-high `rst` is 1, all outputs are 0 and the counter returns to slot 0. The first `frame_end` comes `FRAME_BITS` clocks after the last reset edge.
- R6: `oh_flag` is 1 for slot s exactly when s mod `BLOCK_BITS` is 0. That gives `SUBFRAMES*BLOCKS_PER_SUB` overhead slots per frame (56 by default).
- R7: `frame_end` and `oh_flag` are never 1 in the same clock.
- R8: The `ser_in` value sampled in an overhead slot has no effect on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial payload bit from the terminal equipment |
| oh_bit | input | 1 | Register-supplied overhead bit, used in overhead slots |
| ser_out | output | 1 | Merged payload/overhead serial stream |
| oh_flag | output | 1 | High while the output slot is an overhead slot |
| frame_end | output | 1 | High for the last slot of each M-frame |

## Verification
The bench builds two copies side by side from the same random stimulus. One copy uses the default 7 x 8 x 85 geometry, so the exact 4760-clock distance from reset to the first frame pulse and the 56-slot overhead spacing are checked as they would be in the real part. The other copy uses 3 x 2 x 5 (30-slot frames), which brings hundreds of frame wraps within reach, along with pulse spacing, overhead counts per frame and a reset applied in the middle of a frame.

// File: rtl/ds3_txs_pkg.sv
package ds3_txs_pkg;

    // One registered output slot of the merge stage
    typedef struct packed {
        logic ser;
        logic oh;
        logic fend;
    } slot_out_t;

endpackage

// File: rtl/ds3_slot_counter.sv
module ds3_slot_counter #(
    parameter int BLOCK_BITS     = 85,
    parameter int BLOCKS_PER_SUB = 8,
    parameter int SUBFRAMES      = 7
) (
    input  logic clk,
    input  logic rst,
    output logic is_oh,
    output logic is_last
);
    localparam int BIT_W = (BLOCK_BITS     > 1) ? $clog2(BLOCK_BITS)     : 1;
    localparam int BLK_W = (BLOCKS_PER_SUB > 1) ? $clog2(BLOCKS_PER_SUB) : 1;
    localparam int SUB_W = (SUBFRAMES      > 1) ? $clog2(SUBFRAMES)      : 1;

    typedef struct packed {
        logic [BIT_W-1:0] bitn;
        logic [BLK_W-1:0] blk;
        logic [SUB_W-1:0] sub;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic bit_wrap, blk_wrap, sub_wrap;

    always_comb begin
        bit_wrap = (cnt_q.bitn == BIT_W'(BLOCK_BITS - 1));
        blk_wrap = (cnt_q.blk  == BLK_W'(BLOCKS_PER_SUB - 1));
        sub_wrap = (cnt_q.sub  == SUB_W'(SUBFRAMES - 1));
        cnt_d    = cnt_q;
        if (bit_wrap) begin
            cnt_d.bitn = '0;
            if (blk_wrap) begin
                cnt_d.blk = '0;
                cnt_d.sub = sub_wrap ? '0 : cnt_q.sub + 1'b1;
            end else begin
                cnt_d.blk = cnt_q.blk + 1'b1;
            end
        end else begin
            cnt_d.bitn = cnt_q.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign is_oh   = (cnt_q.bitn == '0);
    assign is_last = bit_wrap && blk_wrap && sub_wrap;

    // R6: bit index stays inside a block
    a_r6_bit_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q.bitn <= BIT_W'(BLOCK_BITS - 1));
    // R4: after the last slot the counter is back at slot 0
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        is_last |=> (cnt_q == '0));
    // R6: block and subframe indices stay in range
    a_r6_blk_range: assert property (@(posedge clk) disable iff (rst)
        (cnt_q.blk <= BLK_W'(BLOCKS_PER_SUB - 1)) && (cnt_q.sub <= SUB_W'(SUBFRAMES - 1)));
endmodule

// File: rtl/ds3_slot_merge.sv
module ds3_slot_merge
    import ds3_txs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic oh_bit,
    input  logic is_oh,
    input  logic is_last,
    output logic ser_out,
    output logic oh_flag,
    output logic frame_end
);
    slot_out_t out_d, out_q;
    logic      live_q;

    always_comb begin
        out_d.ser  = is_oh ? oh_bit : ser_in;
        out_d.oh   = is_oh;
        out_d.fend = is_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            live_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            live_q <= 1'b1;
        end
    end

    assign ser_out   = out_q.ser;
    assign oh_flag   = out_q.oh;
    assign frame_end = out_q.fend;

    // R1: payload slot forwards the bit sampled one clock earlier
    a_r1_payload_pass: assert property (@(posedge clk) disable iff (rst)
        (live_q && !oh_flag) |-> (ser_out == $past(ser_in)));
    // R2: overhead slot carries the overhead bit
    a_r2_oh_pass: assert property (@(posedge clk) disable iff (rst)
        (live_q && oh_flag) |-> (ser_out == $past(oh_bit)));
    // R3: frame pulse lasts one clock
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);
    // R7: strobes never coincide
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && oh_flag));
    // R4: next frame opens with an overhead slot
    a_r4_restart_oh: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> oh_flag);
endmodule

// File: rtl/ds3_frame_master_tx.sv
module ds3_frame_master_tx #(
    parameter int BLOCK_BITS     = 85,
    parameter int BLOCKS_PER_SUB = 8,
    parameter int SUBFRAMES      = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic oh_bit,
    output logic ser_out,
    output logic oh_flag,
    output logic frame_end
);
    localparam int FRAME_BITS = BLOCK_BITS * BLOCKS_PER_SUB * SUBFRAMES;

    logic slot_oh, slot_last;

    ds3_slot_counter #(
        .BLOCK_BITS    (BLOCK_BITS),
        .BLOCKS_PER_SUB(BLOCKS_PER_SUB),
        .SUBFRAMES     (SUBFRAMES)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .is_oh  (slot_oh),
        .is_last(slot_last)
    );

    ds3_slot_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .oh_bit   (oh_bit),
        .is_oh    (slot_oh),
        .is_last  (slot_last),
        .ser_out  (ser_out),
        .oh_flag  (oh_flag),
        .frame_end(frame_end)
    );

    initial begin
        a_r7_geom: assert (BLOCK_BITS > 1 && FRAME_BITS > 1);
    end
endmodule

// File: tb/ds3_frame_master_tx_bench.sv
module ds3_frame_master_tx_bench;
    localparam int FB_L = 85 * 8 * 7;
    localparam int BB_L = 85;
    localparam int FB_S = 5 * 2 * 3;
    localparam int BB_S = 5;
    localparam int NB_S = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic oh_bit = 1'b0;
    logic so_l, oh_l, fe_l, so_s, oh_s, fe_s;

    int checks = 0;
    int errors = 0;
    bit timeout = 1'b0;

    always #5 clk = ~clk;

    ds3_frame_master_tx u_ds3_frame_master_tx (
        .clk(clk), .rst(rst), .ser_in(ser_in), .oh_bit(oh_bit),
        .ser_out(so_l), .oh_flag(oh_l), .frame_end(fe_l));

    ds3_frame_master_tx #(.BLOCK_BITS(5), .BLOCKS_PER_SUB(2), .SUBFRAMES(3)) u_small (
        .clk(clk), .rst(rst), .ser_in(ser_in), .oh_bit(oh_bit),
        .ser_out(so_s), .oh_flag(oh_s), .frame_end(fe_s));

    function automatic bit is_oh_slot(int slot, int bb);
        return (slot % bb) == 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors <= 30) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int  slot_l = 0, slot_s = 0;
    bit  ex_so_l, ex_oh_l, ex_fe_l, ex_so_s, ex_oh_s, ex_fe_s;
    bit  ex_rst = 1'b1;
    bit  ex_valid = 1'b0;
    bit  ex_ign = 1'b0;
    int  edge_n = 0, last_rst_edge = 0;
    int  last_fe_s = -1, oh_cnt_s = 0;
    bit  first_l_seen = 1'b0;

    task automatic step(bit r, bit si, bit ob);
        if (ex_valid) begin
            if (ex_rst) begin
                chk({so_l, oh_l, fe_l, so_s, oh_s, fe_s} == 6'b0, "R5 reset outputs",
                    int'({so_l, oh_l, fe_l, so_s, oh_s, fe_s}), 0);
            end else begin
                chk(oh_l == ex_oh_l, "R6 oh_flag large", oh_l, ex_oh_l);
                chk(oh_s == ex_oh_s, "R6 oh_flag small", oh_s, ex_oh_s);
                chk(fe_l == ex_fe_l, "R3 frame_end large", fe_l, ex_fe_l);
                chk(fe_s == ex_fe_s, "R3 frame_end small", fe_s, ex_fe_s);
                chk(so_l == ex_so_l, ex_oh_l ? "R2 ser_out large" : "R1 ser_out large", so_l, ex_so_l);
                chk(so_s == ex_so_s, ex_oh_s ? "R2 ser_out small" : "R1 ser_out small", so_s, ex_so_s);
                if (ex_ign) chk(so_s == ex_so_s, "R8 payload ignored in overhead", so_s, ex_so_s);
                chk(!(fe_s && oh_s) && !(fe_l && oh_l), "R7 strobe overlap", int'(fe_s & oh_s), 0);
                if (oh_s) oh_cnt_s++;
                if (fe_s) begin
                    if (last_fe_s >= 0) begin
                        chk(edge_n - last_fe_s == FB_S, "R4 pulse spacing", edge_n - last_fe_s, FB_S);
                        chk(oh_cnt_s == NB_S, "R6 overhead per frame", oh_cnt_s, NB_S);
                    end else begin
                        chk(edge_n - last_rst_edge == FB_S, "R5 first pulse small", edge_n - last_rst_edge, FB_S);
                    end
                    last_fe_s = edge_n;
                    oh_cnt_s  = 0;
                end
                if (fe_l && !first_l_seen) begin
                    first_l_seen = 1'b1;
                    chk(edge_n - last_rst_edge == FB_L, "R5 first pulse large", edge_n - last_rst_edge, FB_L);
                end
            end
        end
        // expectation for the coming edge
        ex_valid = 1'b1;
        ex_rst   = r;
        ex_ign   = 1'b0;
        if (r) begin
            slot_l = 0; slot_s = 0;
            last_fe_s = -1; oh_cnt_s = 0; first_l_seen = 1'b0;
        end else begin
            ex_oh_l = is_oh_slot(slot_l, BB_L);
            ex_oh_s = is_oh_slot(slot_s, BB_S);
            ex_fe_l = (slot_l == FB_L - 1);
            ex_fe_s = (slot_s == FB_S - 1);
            ex_so_l = ex_oh_l ? ob : si;
            ex_so_s = ex_oh_s ? ob : si;
            ex_ign  = ex_oh_s && (si != ob);
            slot_l  = (slot_l + 1) % FB_L;
            slot_s  = (slot_s + 1) % FB_S;
        end
        rst = r; ser_in = si; oh_bit = ob;
        @(posedge clk);
        edge_n++;
        if (r) last_rst_edge = edge_n;
        @(negedge clk);
    endtask

    task automatic run_main();
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
        // directed: payload all ones, overhead zeros for first frames (R8)
        for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 12000; i++) begin
            bit rr = (i == 7013) || (i == 7014);
            step(rr, 1'($urandom), 1'($urandom));
        end
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule